// File: doc/BRIEF.md
# Multi-Channel Input Capture FIFO

The block timestamps edges on four input pins against a shared free-running 16-bit timer. Each channel has its own edge detector. A 2-bit mode field selects which edges qualify: none, rising, falling or both. A qualified edge pushes the current timer value into that channel's two-entry FIFO and raises that channel's capture flag.

Software reads a packed status word to see how full each FIFO is and whether any values were discarded. It pops the oldest value of a chosen channel through a read strobe with a channel select. It acknowledges flags by writing ones. The status stays exact when a capture and a pop hit the same channel in the same cycle.

Top module: `mcap_top`

## Requirements
- R1: After reset the timer output is 0. It then increments by one every clock and wraps at 16 bits.
- R2: The edge mode of channel i is `edge_mode_i[2i+1:2i]`: 00 = disabled, 01 = rising, 10 = falling, 11 = both. A pin is sampled at a clock edge. If the sample qualifies, that same clock edge stores the timer value it sees, which is the value `timer_o` showed during the preceding cycle.
- R3: `fifo_stat_o[9+2i:8+2i]` holds the fill state of channel i: 00 empty, 01 one entry, 10 two entries, 11 two entries with at least one older value discarded. Bits 7:0 read 0.
- R4: With two entries stored, successive pops return the older value and then the newer one. Each pop lowers the count by one.
- R5: A capture into a channel holding two entries discards the oldest entry, keeps the newest two, and sets the status to 11.
- R6: A capture and a pop on the same channel in the same cycle, with status 11, return the oldest entry and leave status 10. The new capture becomes the newest entry.
- R7: A pop of an empty channel leaves `pop_data_o` at its previous value and the status at 00.
- R8: `flag_o[i]` (bits 0 to 3) sets on every capture of channel i. A 1 in `flag_clr_i[i]` clears it and a 0 has no effect. A capture in the same cycle as a clear leaves the flag set.
- R9: A pop delivers its value on `pop_data_o` after the clock edge that samples `pop_i`. A pop changes only the selected channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 4 | Capture input pins, one per channel |
| edge_mode_i | input | 8 | 2-bit edge mode per channel |
| pop_i | input | 1 | Pop strobe |
| pop_sel_i | input | 2 | Channel to pop |
| pop_data_o | output | 16 | Last popped timer value |
| fifo_stat_o | output | 16 | Packed fill state, fields at bits 8 to 15 |
| flag_o | output | 4 | Capture flags |
| flag_clr_i | input | 4 | Write-one-to-clear strobe for the flags |
| timer_o | output | 16 | Free-running timebase |

## Verification
A capture and a pop can land on the same channel in the same cycle. The bench sets this up by filling a channel until it has discarded a value (status 11). On one falling clock edge it then drives the pop strobe and toggles that channel's pin together. It then checks that the popped value is the oldest kept entry, that the status reads 10, and that the next two pops return the older kept value and then the capture made during the collision. A flag clear that coincides with a capture is checked the same way: the flag must stay set.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  localparam int unsigned TW        = 16;
  localparam int unsigned NCH       = 4;
  localparam int unsigned STAT_BASE = 8;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_ONE   = 2'b01,
    FILL_TWO   = 2'b10,
    FILL_LOST  = 2'b11
  } fill_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;
endpackage

// File: rtl/mcap_edge.sv
module mcap_edge
  import mcap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  edge_e mode_i,
  output logic  hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  logic rise, fall;
  assign rise  = pin_i & ~prev_q;
  assign fall  = ~pin_i & prev_q;
  assign hit_o = (mode_i[0] & rise) | (mode_i[1] & fall);

  a_r2_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EDGE_OFF) |-> !hit_o);
endmodule

// File: rtl/mcap_fifo.sv
module mcap_fifo
  import mcap_pkg::*;
#(
  parameter int unsigned W = TW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_val_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         head_vld_o,
  output fill_e        stat_o
);
  logic [W-1:0] old_q, new_q;
  fill_e        stat_q;
  logic         full;

  assign full = (stat_q == FILL_TWO) || (stat_q == FILL_LOST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q  <= '0;
      new_q  <= '0;
      stat_q <= FILL_EMPTY;
    end else begin
      unique case ({push_i, pop_i})
        2'b10: begin
          if (stat_q == FILL_EMPTY) begin
            old_q  <= push_val_i;
            stat_q <= FILL_ONE;
          end else if (stat_q == FILL_ONE) begin
            new_q  <= push_val_i;
            stat_q <= FILL_TWO;
          end else begin
            old_q  <= new_q;
            new_q  <= push_val_i;
            stat_q <= FILL_LOST;
          end
        end
        2'b01: begin
          if (full) begin
            old_q  <= new_q;
            stat_q <= FILL_ONE;
          end else begin
            stat_q <= FILL_EMPTY;
          end
        end
        2'b11: begin
          if (full) begin
            old_q  <= new_q;
            new_q  <= push_val_i;
            stat_q <= FILL_TWO;
          end else begin
            old_q  <= push_val_i;
            stat_q <= FILL_ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign head_o     = old_q;
  assign head_vld_o = (stat_q != FILL_EMPTY);
  assign stat_o     = stat_q;

  a_r6_collide_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && stat_q == FILL_LOST) |=> (stat_q == FILL_TWO));
  a_r6_keep_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full) |=> (new_q == $past(push_val_i)));
  a_r5_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full) |=> (stat_q == FILL_LOST && old_q == $past(new_q)));
  a_r7_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && stat_q == FILL_EMPTY) |=> (stat_q == FILL_EMPTY));
  a_r4_pop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && full) |=> (stat_q == FILL_ONE));
endmodule

// File: rtl/mcap_top.sv
module mcap_top
  import mcap_pkg::*;
#(
  parameter int unsigned W = TW,
  parameter int unsigned N = NCH,
  localparam int unsigned SW = $clog2(N),
  localparam int unsigned STW = STAT_BASE + 2 * N
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   cap_pin_i,
  input  logic [2*N-1:0] edge_mode_i,
  input  logic           pop_i,
  input  logic [SW-1:0]  pop_sel_i,
  output logic [W-1:0]   pop_data_o,
  output logic [STW-1:0] fifo_stat_o,
  output logic [N-1:0]   flag_o,
  input  logic [N-1:0]   flag_clr_i,
  output logic [W-1:0]   timer_o
);
  logic [W-1:0] timer_q;
  logic [N-1:0] hit, pop_ch, head_vld;
  logic [W-1:0] head [N];
  fill_e        stat [N];
  logic [N-1:0] flag_q;
  logic [W-1:0] pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_q <= '0;
    else         timer_q <= timer_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign pop_ch[i] = pop_i && (pop_sel_i == SW'(i));

    mcap_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_pin_i[i]),
      .mode_i (edge_e'(edge_mode_i[2*i +: 2])),
      .hit_o  (hit[i])
    );

    mcap_fifo #(.W(W)) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (hit[i]),
      .push_val_i (timer_q),
      .pop_i      (pop_ch[i]),
      .head_o     (head[i]),
      .head_vld_o (head_vld[i]),
      .stat_o     (stat[i])
    );

    assign fifo_stat_o[STAT_BASE + 2*i +: 2] = stat[i];

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_q[i] <= 1'b0;
      else if (hit[i])        flag_q[i] <= 1'b1;
      else if (flag_clr_i[i]) flag_q[i] <= 1'b0;
    end

    a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> flag_q[i]);
    a_r9_pop_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pop_ch[i] && !hit[i]) |=> $stable(stat[i]));
  end

  assign fifo_stat_o[STAT_BASE-1:0] = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pop_q <= '0;
    else if (pop_i && head_vld[pop_sel_i]) pop_q <= head[pop_sel_i];
  end

  assign pop_data_o = pop_q;
  assign flag_o     = flag_q;
  assign timer_o    = timer_q;

  a_r1_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (timer_q == W'($past(timer_q) + 1'b1)));
  a_r7_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i) |=> $stable(pop_q));
endmodule

// File: tb/mcap_top_tb.sv
module mcap_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  pin = '0;
  logic [7:0]  mode = '0;
  logic        pop = 0;
  logic [1:0]  sel = '0;
  logic [15:0] pdata;
  logic [15:0] stat;
  logic [3:0]  flag;
  logic [3:0]  clr = '0;
  logic [15:0] tmr;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcap_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .edge_mode_i(mode),
    .pop_i(pop), .pop_sel_i(sel), .pop_data_o(pdata), .fifo_stat_o(stat),
    .flag_o(flag), .flag_clr_i(clr), .timer_o(tmr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fld(int ch);
    return stat[8 + 2*ch +: 2];
  endfunction

  // toggle pin of ch at a negedge, return timer value it should store
  task automatic toggle(int ch, output logic [15:0] t);
    @(negedge clk);
    t = tmr;
    pin[ch] = ~pin[ch];
    @(negedge clk);
  endtask

  task automatic do_pop(int ch);
    @(negedge clk);
    sel = 2'(ch); pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  // {mode, from, to, expect capture}
  localparam logic [4:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    logic [15:0] t1, t2, t3, t4;
    #12;
    chk("R1 reset timer", tmr, 0);
    chk("R3 reset status", stat, 0);
    chk("R8 reset flags", flag, 0);
    chk("R9 reset pop data", pdata, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); t1 = tmr;
    @(negedge clk);
    chk("R1 timer step", tmr, 16'(t1 + 1));

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      mode[1:0] = 2'b00; pin[0] = VEC[v][2];
      @(negedge clk);
      mode[1:0] = VEC[v][4:3];
      @(negedge clk);
      t1 = tmr;
      pin[0] = VEC[v][1];
      @(negedge clk);
      chk("R2 edge mode status", fld(0), VEC[v][0] ? 2'b01 : 2'b00);
      if (VEC[v][0]) begin
        do_pop(0);
        chk("R2 captured value", pdata, t1);
        chk("R3 status after pop", fld(0), 0);
      end
    end
    mode[1:0] = 2'b00;
    clr = 4'b0001; @(negedge clk); clr = 0;

    // R4: two entries, ordered readout
    mode[3:2] = 2'b11;
    toggle(1, t1); toggle(1, t2);
    chk("R3 two entries ch1 field", fld(1), 2'b10);
    chk("R3 low bits zero", stat[7:0], 0);
    do_pop(1);
    chk("R4 first pop oldest", pdata, t1);
    chk("R4 status one", fld(1), 2'b01);
    do_pop(1);
    chk("R4 second pop newer", pdata, t2);
    chk("R4 status empty", fld(1), 2'b00);
    // R7 empty pop
    do_pop(1);
    chk("R7 empty pop data held", pdata, t2);
    chk("R7 empty pop status", fld(1), 2'b00);

    // R5 overflow on ch2
    mode[5:4] = 2'b11;
    toggle(2, t1); toggle(2, t2); toggle(2, t3);
    chk("R5 overflow status", fld(2), 2'b11);
    do_pop(2);
    chk("R5 oldest dropped", pdata, t2);
    chk("R5 pop after overflow", fld(2), 2'b01);
    do_pop(2);
    chk("R5 newest kept", pdata, t3);

    // R6 collision on ch3
    mode[7:6] = 2'b11;
    toggle(3, t1); toggle(3, t2); toggle(3, t3);
    chk("R6 pre status", fld(3), 2'b11);
    chk("R9 other channel untouched", fld(2), 2'b00);
    @(negedge clk);
    t4 = tmr; sel = 2'd3; pop = 1; pin[3] = ~pin[3];
    @(negedge clk);
    pop = 0;
    chk("R6 collide pop data", pdata, t2);
    chk("R6 collide status", fld(3), 2'b10);
    do_pop(3);
    chk("R6 next older", pdata, t3);
    do_pop(3);
    chk("R6 collide capture kept", pdata, t4);

    // R8 flags
    chk("R8 flags set", flag, 4'b1110);
    @(negedge clk); clr = 4'b1000;
    @(negedge clk); clr = 0;
    chk("R8 clear one flag", flag, 4'b0110);
    @(negedge clk); clr = 4'b0000;
    @(negedge clk);
    chk("R8 zero write no effect", flag, 4'b0110);
    @(negedge clk); clr = 4'b1000; pin[3] = ~pin[3];
    @(negedge clk); clr = 0;
    chk("R8 set wins over clear", flag[3], 1'b1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule